// File: doc/BRIEF.md
# Iterative Integer Divider with Condition Flags

This block performs integer division for a processor datapath in one of three forms, chosen by a 2-bit operation code sampled with a start strobe. The first form divides a 16-bit signed dividend by a 16-bit signed divisor. The second divides a 32-bit unsigned dividend, made from two registers, by a 16-bit unsigned divisor. The third uses the same 32-by-16 layout with two's-complement operands. All three share one restoring shift-and-subtract engine that works on magnitudes. Sign handling is applied before the loop and after it.

The block takes the current values of three 16-bit registers: the accumulator D, the index X and the second index Y. It returns the new values these registers take after the divide, so the surrounding register file only has to write them back. It also returns zero, negative, overflow and carry flags. A zero divisor is reported on the carry flag and leaves all three registers unchanged. A one-cycle done pulse marks the cycle in which the results are valid. The results are then held until the next divide completes.

Top module: `int_div_unit`

## Requirements
- R1: Operation code 2'b00 divides signed D by signed X. The quotient is written to X_out and the remainder to D_out, and Y_out keeps the captured Y. The quotient truncates toward zero, and the remainder has the sign of the dividend.
- R2: Operation code 2'b01 divides the unsigned 32-bit value {Y,D} (Y is the high half) by unsigned X. The low 16 bits of the quotient go to Y_out and the remainder to D_out, and X_out keeps the captured X.
- R3: Operation code 2'b10 uses the R2 register layout with signed {Y,D} and signed X, and the same rounding rules as R1.
- R4: When the divisor X is zero, C is 1, Z, N and V are 0, D_out, X_out and Y_out equal the operands captured at start, and done still pulses. Every divide with a nonzero divisor clears C.
- R5: Z is 1 exactly when the full quotient is zero. N equals bit 15 of the quotient value written out.
- R6: V is set for 2'b01 when the quotient is 65536 or more. V is set for 2'b00 and 2'b10 when the quotient lies outside -32768..32767. In both cases the low 16 bits of the quotient are still written.
- R7: done_o is high for exactly one clock per completed divide. The outputs change only on that cycle and hold their values at all other times.
- R8: A start while a divide is in progress is ignored and does not alter the running divide. A start with operation code 2'b11 is ignored and produces no done.
- R9: Let the accepting clock edge be edge 0. done_o rises after edge 17 for 2'b00, after edge 33 for 2'b01 and 2'b10, and after edge 1 when the divisor is zero.
- R10: After reset, D_out, X_out, Y_out, all flags and done_o are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start strobe, sampled on the rising edge |
| op_i | input | 2 | Operation code: 00 signed 16/16, 01 unsigned 32/16, 10 signed 32/16, 11 ignored |
| d_i | input | 16 | Current D register value |
| x_i | input | 16 | Current X register value |
| y_i | input | 16 | Current Y register value |
| d_o | output | 16 | New D register value |
| x_o | output | 16 | New X register value |
| y_o | output | 16 | New Y register value |
| z_o | output | 1 | Zero flag |
| n_o | output | 1 | Negative flag |
| v_o | output | 1 | Overflow flag |
| c_o | output | 1 | Carry flag, 1 on a zero divisor |
| done_o | output | 1 | One-cycle pulse when the outputs hold a new result |

## Verification
Some properties are checked on every cycle:
- done is a single-cycle pulse, and the outputs move only with it.
- The carry flag agrees with the captured divisor being zero, and a zero divisor returns all three registers unchanged.
- The register that a form does not write keeps its captured value.
- A zero quotient never shows as negative.
- A start during a busy divide leaves the captured operands alone.
- A busy period never exceeds the longest iteration count.

The bench alone can show that the quotient and remainder values are correct, including the truncation direction and the remainder sign. It also covers the overflow boundaries of each form, the exact latency of each form, and the fact that a reserved operation code produces nothing.

// File: rtl/int_div_pkg.sv
package int_div_pkg;

  typedef enum logic [1:0] {
    OP_SDIV16 = 2'b00,
    OP_UDIV32 = 2'b01,
    OP_SDIV32 = 2'b10,
    OP_RSVD   = 2'b11
  } div_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_FIN  = 2'b10
  } core_st_e;

endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep
  import int_div_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [1:0]     op_i,
  input  logic [W-1:0]   d_i,
  input  logic [W-1:0]   x_i,
  input  logic [W-1:0]   y_i,
  output logic [2*W-1:0] dd_mag_o,
  output logic [W-1:0]   dv_mag_o,
  output logic           neg_q_o,
  output logic           neg_r_o,
  output logic           short_o,
  output logic           div0_o
);

  logic           signed_op;
  logic [2*W-1:0] dd_raw;
  logic           dd_neg;
  logic           dv_neg;

  always_comb begin
    short_o   = (op_i == OP_SDIV16);
    signed_op = (op_i != OP_UDIV32);
    dd_raw    = short_o ? {{W{d_i[W-1]}}, d_i} : {y_i, d_i};
    dd_neg    = signed_op && dd_raw[2*W-1];
    dv_neg    = signed_op && x_i[W-1];
    dd_mag_o  = dd_neg ? (~dd_raw + 1'b1) : dd_raw;
    dv_mag_o  = dv_neg ? (~x_i + 1'b1) : x_i;
    neg_q_o   = dd_neg ^ dv_neg;
    neg_r_o   = dd_neg;
    div0_o    = (x_i == '0);
  end

endmodule

// File: rtl/div_core.sv
module div_core
  import int_div_pkg::*;
#(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go_i,
  input  logic           short_i,
  input  logic           div0_i,
  input  logic [2*W-1:0] dd_mag_i,
  input  logic [W-1:0]   dv_mag_i,
  output logic           busy_o,
  output logic           fin_o,
  output logic [2*W-1:0] q_mag_o,
  output logic [W-1:0]   r_mag_o
);

  localparam int CW = $clog2(2*W + 1);
  localparam logic [CW-1:0] SHORT_STEPS = CW'(W);
  localparam logic [CW-1:0] LONG_STEPS  = CW'(2*W);

  core_st_e       state_q, state_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [2*W-1:0] quo_q, quo_d;
  logic [W-1:0]   rem_q, rem_d;
  logic [W-1:0]   dv_q, dv_d;
  logic           en;

  logic [W:0]     shifted;
  logic [W-1:0]   diff;
  logic           ge;

  // one restoring step: shift in the next dividend bit, try a subtract
  always_comb begin
    shifted = {rem_q, quo_q[2*W-1]};
    ge      = (shifted >= {1'b0, dv_q});
    diff    = shifted[W-1:0] - dv_q;
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    quo_d   = quo_q;
    rem_d   = rem_q;
    dv_d    = dv_q;
    case (state_q)
      ST_IDLE: begin
        if (go_i) begin
          dv_d    = dv_mag_i;
          rem_d   = '0;
          quo_d   = short_i ? {dd_mag_i[W-1:0], {W{1'b0}}} : dd_mag_i;
          cnt_d   = short_i ? SHORT_STEPS : LONG_STEPS;
          state_d = div0_i ? ST_FIN : ST_RUN;
        end
      end
      ST_RUN: begin
        rem_d = ge ? diff : shifted[W-1:0];
        quo_d = {quo_q[2*W-2:0], ge};
        cnt_d = cnt_q - 1'b1;
        if (cnt_q == CW'(1)) state_d = ST_FIN;
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign en = (state_q != ST_IDLE) || go_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      quo_q   <= '0;
      rem_q   <= '0;
      dv_q    <= '0;
    end else if (en) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      quo_q   <= quo_d;
      rem_q   <= rem_d;
      dv_q    <= dv_d;
    end
  end

  assign busy_o  = (state_q != ST_IDLE);
  assign fin_o   = (state_q == ST_FIN);
  assign q_mag_o = quo_q;
  assign r_mag_o = rem_q;

endmodule

// File: rtl/div_result_map.sv
module div_result_map
  import int_div_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [1:0]     op_i,
  input  logic           div0_i,
  input  logic           neg_q_i,
  input  logic           neg_r_i,
  input  logic [2*W-1:0] q_mag_i,
  input  logic [W-1:0]   r_mag_i,
  input  logic [W-1:0]   d_i,
  input  logic [W-1:0]   x_i,
  input  logic [W-1:0]   y_i,
  output logic [W-1:0]   d_o,
  output logic [W-1:0]   x_o,
  output logic [W-1:0]   y_o,
  output logic           z_o,
  output logic           n_o,
  output logic           v_o,
  output logic           c_o
);

  // largest positive and negative quotient magnitudes that fit W signed bits
  localparam logic [2*W-1:0] POS_LIM = {{(W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic [2*W-1:0] NEG_LIM = {{W{1'b0}}, 1'b1, {(W-1){1'b0}}};

  logic [W-1:0] q_low;
  logic [W-1:0] r_val;
  logic         v_raw;

  always_comb begin
    q_low = neg_q_i ? (~q_mag_i[W-1:0] + 1'b1) : q_mag_i[W-1:0];
    r_val = neg_r_i ? (~r_mag_i + 1'b1) : r_mag_i;
    if (op_i == OP_UDIV32) v_raw = |q_mag_i[2*W-1:W];
    else if (neg_q_i)      v_raw = (q_mag_i > NEG_LIM);
    else                   v_raw = (q_mag_i > POS_LIM);

    d_o = d_i;
    x_o = x_i;
    y_o = y_i;
    z_o = 1'b0;
    n_o = 1'b0;
    v_o = 1'b0;
    c_o = 1'b1;
    if (!div0_i) begin
      c_o = 1'b0;
      z_o = (q_mag_i == '0);
      n_o = q_low[W-1];
      v_o = v_raw;
      d_o = r_val;
      if (op_i == OP_SDIV16) x_o = q_low;
      else                   y_o = q_low;
    end
  end

endmodule

// File: rtl/int_div_unit.sv
module int_div_unit
  import int_div_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [1:0]   op_i,
  input  logic [W-1:0] d_i,
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] d_o,
  output logic [W-1:0] x_o,
  output logic [W-1:0] y_o,
  output logic         z_o,
  output logic         n_o,
  output logic         v_o,
  output logic         c_o,
  output logic         done_o
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [2*W-1:0] dd_mag, q_mag;
  logic [W-1:0]   dv_mag, r_mag;
  logic           neg_q, neg_r, short_op, div0;
  logic           core_busy, core_fin, go;

  div_operand_prep #(.W(W)) prep_i (
    .op_i(op_i), .d_i(d_i), .x_i(x_i), .y_i(y_i),
    .dd_mag_o(dd_mag), .dv_mag_o(dv_mag),
    .neg_q_o(neg_q), .neg_r_o(neg_r), .short_o(short_op), .div0_o(div0)
  );

  assign go = start_i && !core_busy && (op_i != OP_RSVD);

  div_core #(.W(W)) core_i (
    .clk(clk), .rst_n(rst_int_n), .go_i(go), .short_i(short_op),
    .div0_i(div0), .dd_mag_i(dd_mag), .dv_mag_i(dv_mag),
    .busy_o(core_busy), .fin_o(core_fin), .q_mag_o(q_mag), .r_mag_o(r_mag)
  );

  // operands and sign decisions captured when a divide is accepted
  logic [1:0]   op_cap;
  logic [W-1:0] d_cap, x_cap, y_cap;
  logic         negq_cap, negr_cap, div0_cap;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      op_cap   <= 2'b00;
      d_cap    <= '0;
      x_cap    <= '0;
      y_cap    <= '0;
      negq_cap <= 1'b0;
      negr_cap <= 1'b0;
      div0_cap <= 1'b0;
    end else if (go) begin
      op_cap   <= op_i;
      d_cap    <= d_i;
      x_cap    <= x_i;
      y_cap    <= y_i;
      negq_cap <= neg_q;
      negr_cap <= neg_r;
      div0_cap <= div0;
    end
  end

  logic [W-1:0] d_nx, x_nx, y_nx;
  logic         z_nx, n_nx, v_nx, c_nx;

  div_result_map #(.W(W)) map_i (
    .op_i(op_cap), .div0_i(div0_cap), .neg_q_i(negq_cap), .neg_r_i(negr_cap),
    .q_mag_i(q_mag), .r_mag_i(r_mag),
    .d_i(d_cap), .x_i(x_cap), .y_i(y_cap),
    .d_o(d_nx), .x_o(x_nx), .y_o(y_nx),
    .z_o(z_nx), .n_o(n_nx), .v_o(v_nx), .c_o(c_nx)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      d_o <= '0;
      x_o <= '0;
      y_o <= '0;
      z_o <= 1'b0;
      n_o <= 1'b0;
      v_o <= 1'b0;
      c_o <= 1'b0;
    end else if (core_fin) begin
      d_o <= d_nx;
      x_o <= x_nx;
      y_o <= y_nx;
      z_o <= z_nx;
      n_o <= n_nx;
      v_o <= v_nx;
      c_o <= c_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) done_o <= 1'b0;
    else            done_o <= core_fin;
  end

endmodule

// File: rtl/int_div_unit_chk.sv
module int_div_unit_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start_i,
  input logic         done_o,
  input logic [W-1:0] d_o,
  input logic [W-1:0] x_o,
  input logic [W-1:0] y_o,
  input logic         z_o,
  input logic         n_o,
  input logic         v_o,
  input logic         c_o,
  input logic         busy,
  input logic [1:0]   op_cap,
  input logic [W-1:0] d_cap,
  input logic [W-1:0] x_cap,
  input logic [W-1:0] y_cap
);

  localparam int BUSY_MAX = 2*W + 1;
  localparam int BCW = $clog2(BUSY_MAX + 2);

  logic [BCW-1:0] busy_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 1'b1;
    else           busy_cnt <= '0;
  end

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (done_o || ($stable(d_o) && $stable(x_o) && $stable(y_o))));

  assert_div0_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (c_o == (x_cap == '0)));

  assert_div0_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && c_o) |-> (d_o == d_cap && x_o == x_cap && y_o == y_cap && !z_o && !n_o && !v_o));

  assert_short_keeps_y_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && op_cap == 2'b00) |-> (y_o == y_cap));

  assert_long_keeps_x_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && op_cap != 2'b00) |-> (x_o == x_cap));  // also R3

  assert_zero_not_neg_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && z_o) |-> (!n_o && (op_cap != 2'b00 || x_o == '0)));

  assert_busy_ignores_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_i) |=> ($stable(op_cap) && $stable(d_cap) && $stable(x_cap) && $stable(y_cap)));

  assert_latency_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt <= BCW'(BUSY_MAX));

endmodule

bind int_div_unit int_div_unit_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .done_o(done_o),
  .d_o(d_o), .x_o(x_o), .y_o(y_o),
  .z_o(z_o), .n_o(n_o), .v_o(v_o), .c_o(c_o),
  .busy(core_busy), .op_cap(op_cap),
  .d_cap(d_cap), .x_cap(x_cap), .y_cap(y_cap)
);

// File: tb/int_div_unit_tb_top.sv
`timescale 1ns/1ps
module int_div_unit_tb_top;

  typedef struct packed {
    logic [15:0] d;
    logic [15:0] x;
    logic [15:0] y;
    logic z, n, v, c;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [1:0]  op_i;
  logic [15:0] d_i, x_i, y_i;
  logic [15:0] d_o, x_o, y_o;
  logic        z_o, n_o, v_o, c_o, done_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  int_div_unit #(.W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
    .d_i(d_i), .x_i(x_i), .y_i(y_i),
    .d_o(d_o), .x_o(x_o), .y_o(y_o),
    .z_o(z_o), .n_o(n_o), .v_o(v_o), .c_o(c_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [1:0] op, input logic [15:0] d, input logic [15:0] x, input logic [15:0] y);
    exp_t e;
    longint a, b, q, r;
    e.d = d; e.x = x; e.y = y;
    e.z = 1'b0; e.n = 1'b0; e.v = 1'b0; e.c = 1'b0;
    if (x == 16'h0) begin
      e.c = 1'b1;
      return e;
    end
    case (op)
      2'b00:   begin a = longint'($signed(d));      b = longint'($signed(x)); end
      2'b01:   begin a = longint'({y, d});          b = longint'(x);          end
      default: begin a = longint'($signed({y, d})); b = longint'($signed(x)); end
    endcase
    q = a / b;
    r = a % b;
    e.z = (q == 0);
    e.n = q[15];
    if (op == 2'b01) e.v = (q > 65535);
    else             e.v = (q > 32767) || (q < -32768);
    e.d = r[15:0];
    if (op == 2'b00) e.x = q[15:0];
    else             e.y = q[15:0];
    return e;
  endfunction

  task automatic run_op(input logic [1:0] op, input logic [15:0] d, input logic [15:0] x,
                        input logic [15:0] y, input bit interfere);
    exp_t  e;
    int    k, lat;
    bit    seen;
    string tag;
    logic [15:0] hd, hx, hy;
    e   = model(op, d, x, y);
    lat = (x == 16'h0) ? 2 : ((op == 2'b00) ? 18 : 34);
    if (x == 16'h0)      tag = "R4";
    else if (op == 2'b00) tag = "R1";
    else if (op == 2'b01) tag = "R2";
    else                  tag = "R3";
    @(negedge clk);
    op_i = op; d_i = d; x_i = x; y_i = y; start_i = 1'b1;
    @(posedge clk);
    k = 0; seen = 1'b0;
    while (k < 45 && !seen) begin
      @(negedge clk);
      k++;
      if (k == 1) begin
        start_i = 1'b0;
        d_i = 16'($urandom); x_i = 16'($urandom); y_i = 16'($urandom);
      end
      if (interfere && k == 4) begin start_i = 1'b1; op_i = 2'($urandom % 3); end
      if (interfere && k == 5) start_i = 1'b0;
      if (done_o) seen = 1'b1;
    end
    chk(seen && k == lat, interfere ? "R8 R9 latency" : "R9 latency", 64'(k), 64'(lat));
    chk({d_o, x_o, y_o} == {e.d, e.x, e.y}, interfere ? {tag, " R8 regs"} : {tag, " regs"},
        {16'h0, d_o, x_o, y_o}, {16'h0, e.d, e.x, e.y});
    chk(z_o == e.z && n_o == e.n, {tag, " R5 Z/N"}, {z_o, n_o}, {e.z, e.n});
    chk(v_o == e.v && c_o == e.c, {tag, " R6 R4 V/C"}, {v_o, c_o}, {e.v, e.c});
    hd = d_o; hx = x_o; hy = y_o;
    @(negedge clk);
    chk(!done_o && {d_o, x_o, y_o} == {hd, hx, hy}, "R7 pulse/hold",
        {done_o, d_o, x_o, y_o}, {1'b0, hd, hx, hy});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [15:0] hd, hx, hy;
    bit got;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start_i = 1'b0; op_i = 2'b00; d_i = '0; x_i = '0; y_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk({d_o, x_o, y_o, z_o, n_o, v_o, c_o, done_o} == '0, "R10 reset",
        64'({d_o, x_o, y_o, z_o, n_o, v_o, c_o, done_o}), 64'h0);

    // directed corners
    run_op(2'b00, 16'd7,    16'hFFFE, 16'h1234, 1'b0); // R1 7/-2
    run_op(2'b00, 16'hFFF9, 16'd2,    16'h5555, 1'b0); // R1 -7/2
    run_op(2'b00, 16'h8000, 16'hFFFF, 16'h0000, 1'b0); // R6 overflow 16
    run_op(2'b00, 16'd0,    16'd5,    16'hABCD, 1'b0); // R5 zero
    run_op(2'b00, 16'h8000, 16'd1,    16'h0000, 1'b0); // R5 negative limit
    run_op(2'b01, 16'hFFFF, 16'd1,    16'hFFFF, 1'b0); // R6 unsigned overflow
    run_op(2'b01, 16'hFFFF, 16'd2,    16'h0001, 1'b0); // R6 just below 65536 -> ffff
    run_op(2'b01, 16'h0000, 16'd2,    16'h0002, 1'b0); // R6 exactly 65536
    run_op(2'b10, 16'h0000, 16'hFFFF, 16'h8000, 1'b0); // R3 R6 most negative / -1
    run_op(2'b10, 16'h8000, 16'd1,    16'hFFFF, 1'b0); // R3 -32768 fits
    run_op(2'b10, 16'h7FFF, 16'd1,    16'h0000, 1'b0); // R3 +32767 fits
    run_op(2'b10, 16'hFFF9, 16'd2,    16'hFFFF, 1'b0); // R3 -7/2
    run_op(2'b00, 16'h1234, 16'h0000, 16'h5678, 1'b0); // R4
    run_op(2'b01, 16'h4321, 16'h0000, 16'h8765, 1'b0); // R4
    run_op(2'b10, 16'h1111, 16'h0000, 16'h2222, 1'b0); // R4
    run_op(2'b01, 16'h1000, 16'd3,    16'h0000, 1'b1); // R8 start while busy
    run_op(2'b00, 16'h0100, 16'hFFF0, 16'h0000, 1'b1); // R8 start while busy

    // R8: reserved code produces nothing
    hd = d_o; hx = x_o; hy = y_o; got = 1'b0;
    @(negedge clk);
    op_i = 2'b11; d_i = 16'd100; x_i = 16'd3; y_i = 16'd0; start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (done_o) got = 1'b1;
    end
    chk(!got && {d_o, x_o, y_o} == {hd, hx, hy}, "R8 reserved op",
        {got, d_o, x_o, y_o}, {1'b0, hd, hx, hy});

    // random mix
    for (int i = 0; i < 250; i++) begin
      logic [1:0]  op;
      logic [15:0] d, x, y;
      int sel;
      op  = 2'($urandom % 3);
      d   = 16'($urandom);
      y   = 16'($urandom);
      sel = int'($urandom % 8);
      if (sel == 0)      x = 16'h0000;
      else if (sel == 1) x = 16'hFFFF;
      else if (sel < 4)  x = 16'($urandom % 15 + 1);
      else               x = 16'($urandom);
      if ($urandom % 2 == 1) y = (op == 2'b10) ? {16{d[15]}} : 16'($urandom % 4);
      run_op(op, d, x, y, ($urandom % 6) == 0);
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule